// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block sits on the device side of a fast-page-mode dynamic memory and watches the four active-low control strobes: row strobe, column strobe, write enable and output enable. The strobes are assumed to be already sampled into the block's clock domain. From the order in which their edges arrive, the block decides what kind of cycle the controller is running. The kinds are a normal read, an early write, a read-modify-write, a row-address-only refresh, a column-before-row refresh, a hidden refresh, or an illegal sequence. It reports each decision as a one-cycle pulse together with a 3-bit kind code.

The block keeps the internal refresh row counter. The counter serves the refresh forms that do not carry a row address, and it steps once for each such refresh. Every refresh produces a pulse and the row to restore. That row is the address latched when the row strobe fell for a row-address-only refresh, or the counter value for the other two refresh forms. Every write produces a strobe. The output-driver enable is produced from the strobe state so that read data stays driven across a hidden refresh. An early write never turns the driver on. An illegal sequence raises an "undefined output" flag instead of the enable. The memory array itself lies outside the block.

Top module: `dram_cycle_classifier`

## Requirements
- R1: After reset, `cyc_kind` is 0, `cyc_valid`, `refresh_fire`, `wr_strobe`, `dout_en` and `dout_undef` are 0, `refresh_row` is 0, and the internal refresh counter holds 0, so the first counter-based refresh reports row 0.
- R2: When the row strobe falls with the column strobe high, a later column strobe fall with write enable high is reported as a read (`cyc_kind` = 1, `cyc_valid` pulse) one clock after the sampled edge.
- R3: When write enable is already low at the column strobe fall, the cycle is an early write (`cyc_kind` = 2). `wr_strobe` pulses in the same cycle as `cyc_valid`, and `dout_en` stays 0 for that access even with output enable low.
- R4: During a read with the column strobe still low, a fall of write enable turns the access into a read-modify-write (`cyc_kind` = 3) with a `wr_strobe` pulse. `dout_en` stays 1 both before and at that point.
- R5: When the row strobe falls and rises again with no column strobe fall in between, the block reports a row-address-only refresh (`cyc_kind` = 4) at the row strobe rise. `refresh_fire` pulses and `refresh_row` equals the address sampled at the row strobe fall.
- R6: When the column strobe is already low as the row strobe falls from idle, the block reports a column-before-row refresh (`cyc_kind` = 5) with `refresh_fire`. `refresh_row` is the counter value and the address pins are ignored. The counter then steps by one and wraps from 2^ROW_W-1 to 0.
- R7: When the row strobe rises and falls again while the column strobe stays low after a read, the block reports a hidden refresh (`cyc_kind` = 6) that uses and steps the counter, and `dout_en` stays 1 throughout.
- R8: `dout_en` is 1 only while the column strobe and output enable are both low during a read-type access. It drops one clock after either of them rises and returns one clock after both are low again.
- R9: A column strobe fall while the row strobe is low inside a counter-based refresh is illegal. It reports `cyc_kind` = 7. While the column strobe and output enable are low in that state, `dout_undef` is 1 and `dout_en` is 0. The flag clears once both strobes are high.
- R10: Several column strobe pulses within one row strobe low period are each classified on their own, read or early write. The final row strobe rise after any column access reports no refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Sampled row strobe, active low |
| cas_n | input | 1 | Sampled column strobe, active low |
| we_n | input | 1 | Sampled write enable, active low |
| oe_n | input | 1 | Sampled output enable, active low |
| addr | input | ROW_W | Address pins, taken as the row at the row strobe fall |
| cyc_kind | output | 3 | Last decided cycle kind (codes per R2 to R9) |
| cyc_valid | output | 1 | One-cycle pulse when `cyc_kind` is newly decided |
| refresh_row | output | ROW_W | Row to restore, valid with `refresh_fire` |
| refresh_fire | output | 1 | One-cycle pulse for every refresh |
| dout_en | output | 1 | Data output driver enable |
| dout_undef | output | 1 | Output state undefined (illegal sequence) |
| wr_strobe | output | 1 | One-cycle pulse when write data is to be latched |

## Verification
The hardest state to reach is the hidden refresh. It exists only after a read has put data on the output, followed by a row strobe rise and a second fall while the column strobe is held low the whole time. The bench builds that sequence edge by edge and checks that the driver enable never drops across the gap. The illegal-sequence path is also hard to reach. The bench gets there by starting a counter-based refresh and then raising and lowering the column strobe while the row strobe stays low. Counter wrap is reached by running enough counter-based refreshes to walk the whole row range.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_READ    = 3'd1,
        K_EWRITE  = 3'd2,
        K_RMW     = 3'd3,
        K_RASONLY = 3'd4,
        K_CBR     = 3'd5,
        K_HIDDEN  = 3'd6,
        K_ERROR   = 3'd7
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_ACC,
        ST_REF,
        ST_HREF,
        ST_HOLD,
        ST_ERR
    } ctl_state_e;

endpackage

// File: rtl/strobe_history.sv
module strobe_history #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strb,
    output logic [N-1:0] prev
);
    logic [N-1:0] hist_d, hist_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb hist_d[i] = strb[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '1;
        else        hist_q <= hist_d;
    end

    assign prev = hist_q;
endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bump,
    output logic [W-1:0] value
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (bump) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q;

    // R6: one step per counter-based refresh, wrapping modulo 2^W
    assert_counter_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bump) && $past(rst_n) |-> value == $past(value) + 1'b1);
    assert_counter_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bump) && $past(rst_n) |-> $stable(value));
endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
    import dcc_pkg::*;
#(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [ROW_W-1:0] addr,
    output logic [2:0]       cyc_kind,
    output logic             cyc_valid,
    output logic [ROW_W-1:0] refresh_row,
    output logic             refresh_fire,
    output logic             dout_en,
    output logic             dout_undef,
    output logic             wr_strobe
);
    localparam int NSTRB = 3;

    typedef struct packed {
        ctl_state_e       st;
        logic [ROW_W-1:0] row;
        logic             col_seen;
        cyc_kind_e        acc;
        cyc_kind_e        kind;
        logic             kvalid;
        logic             fire;
        logic [ROW_W-1:0] rrow;
        logic             wr;
        logic             den;
        logic             dundef;
    } ctl_t;

    ctl_t             s_d, s_q;
    logic [NSTRB-1:0] prev;
    logic [ROW_W-1:0] cnt;
    logic             bump;
    logic             ras_fall, ras_rise, cas_fall, cas_rise, we_fall, keep;

    strobe_history #(.N(NSTRB)) u_hist (
        .clk  (clk),
        .rst_n(rst_n),
        .strb ({we_n, cas_n, ras_n}),
        .prev (prev)
    );

    refresh_row_counter #(.W(ROW_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .bump (bump),
        .value(cnt)
    );

    always_comb begin
        ras_fall = prev[0] & ~ras_n;
        ras_rise = ~prev[0] & ras_n;
        cas_fall = prev[1] & ~cas_n;
        cas_rise = ~prev[1] & cas_n;
        we_fall  = prev[2] & ~we_n;
        keep     = ~cas_n & ~oe_n;

        s_d        = s_q;
        s_d.kvalid = 1'b0;
        s_d.fire   = 1'b0;
        s_d.wr     = 1'b0;
        bump       = 1'b0;

        case (s_q.st)
            ST_IDLE: begin
                if (ras_fall) begin
                    if (!cas_n) begin
                        s_d.st     = ST_REF;
                        s_d.kind   = K_CBR;
                        s_d.kvalid = 1'b1;
                        s_d.fire   = 1'b1;
                        s_d.rrow   = cnt;
                        bump       = 1'b1;
                    end else begin
                        s_d.st       = ST_ROW;
                        s_d.row      = addr;
                        s_d.col_seen = 1'b0;
                    end
                end
            end
            ST_ROW: begin
                if (ras_rise) begin
                    s_d.st = ST_IDLE;
                    if (!s_q.col_seen) begin
                        s_d.kind   = K_RASONLY;
                        s_d.kvalid = 1'b1;
                        s_d.fire   = 1'b1;
                        s_d.rrow   = s_q.row;
                    end
                end else if (cas_fall) begin
                    s_d.st       = ST_ACC;
                    s_d.col_seen = 1'b1;
                    s_d.kvalid   = 1'b1;
                    if (!we_n) begin
                        s_d.acc  = K_EWRITE;
                        s_d.kind = K_EWRITE;
                        s_d.wr   = 1'b1;
                    end else begin
                        s_d.acc  = K_READ;
                        s_d.kind = K_READ;
                    end
                end
            end
            ST_ACC: begin
                if (ras_rise) begin
                    s_d.st = (cas_n || s_q.acc == K_EWRITE) ? ST_IDLE : ST_HOLD;
                end else if (cas_rise) begin
                    s_d.st = ST_ROW;
                end else if (we_fall && s_q.acc == K_READ) begin
                    s_d.acc    = K_RMW;
                    s_d.kind   = K_RMW;
                    s_d.kvalid = 1'b1;
                    s_d.wr     = 1'b1;
                end
            end
            ST_REF: begin
                if (ras_rise) begin
                    s_d.st = ST_IDLE;
                end else if (cas_fall) begin
                    s_d.st     = ST_ERR;
                    s_d.kind   = K_ERROR;
                    s_d.kvalid = 1'b1;
                end
            end
            ST_HREF: begin
                if (ras_rise)      s_d.st = cas_n ? ST_IDLE : ST_HOLD;
                else if (cas_rise) s_d.st = ST_REF;
            end
            ST_HOLD: begin
                if (cas_n) begin
                    s_d.st = ST_IDLE;
                    if (ras_fall) begin
                        s_d.st       = ST_ROW;
                        s_d.row      = addr;
                        s_d.col_seen = 1'b0;
                    end
                end else if (ras_fall) begin
                    s_d.st     = ST_HREF;
                    s_d.kind   = K_HIDDEN;
                    s_d.kvalid = 1'b1;
                    s_d.fire   = 1'b1;
                    s_d.rrow   = cnt;
                    bump       = 1'b1;
                end
            end
            ST_ERR: begin
                if (ras_n && cas_n) s_d.st = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase

        s_d.den = keep && ((s_d.st == ST_ACC && s_d.acc != K_EWRITE) ||
                           s_d.st == ST_HOLD || s_d.st == ST_HREF);
        s_d.dundef = keep && (s_d.st == ST_ERR);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, row: '0, col_seen: 1'b0, acc: K_NONE,
                     kind: K_NONE, kvalid: 1'b0, fire: 1'b0, rrow: '0,
                     wr: 1'b0, den: 1'b0, dundef: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cyc_kind     = s_q.kind;
    assign cyc_valid    = s_q.kvalid;
    assign refresh_row  = s_q.rrow;
    assign refresh_fire = s_q.fire;
    assign dout_en      = s_q.den;
    assign dout_undef   = s_q.dundef;
    assign wr_strobe    = s_q.wr;

    // R3: an early write never drives data and always latches it
    assert_ewrite_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && cyc_kind == K_EWRITE |-> !dout_en && wr_strobe);
    // R4: a read-modify-write latches data while read data is still driven
    assert_rmw_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid && cyc_kind == K_RMW |-> wr_strobe);
    // R5: row-address-only refresh is decided at the row strobe rise
    assert_rasonly_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_fire && cyc_kind == K_RASONLY |-> $past(ras_n));
    // R6: counter-based refresh needs the column strobe low first
    assert_cbr_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_fire && cyc_kind == K_CBR |-> !$past(cas_n) && !$past(ras_n));
    // R8: the driver is on only while both strobes were low
    assert_drive_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !$past(cas_n) && !$past(oe_n));
    // R9: undefined output and driver enable are exclusive
    assert_undef_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(dout_en && dout_undef));
    // R10: refresh and write pulses never coincide
    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({refresh_fire, wr_strobe}));
endmodule

// File: tb/tb_dram_cycle_classifier.sv
module tb_dram_cycle_classifier;
    localparam int ROW_W = 9;
    localparam int NROWS = 1 << ROW_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ROW_W-1:0] addr = '0;
    logic [2:0] cyc_kind;
    logic cyc_valid, refresh_fire, dout_en, dout_undef, wr_strobe;
    logic [ROW_W-1:0] refresh_row;

    int n_chk = 0;
    int n_err = 0;
    int exp_cnt = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dram_cycle_classifier #(.ROW_W(ROW_W)) dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .cyc_kind(cyc_kind), .cyc_valid(cyc_valid),
        .refresh_row(refresh_row), .refresh_fire(refresh_fire), .dout_en(dout_en),
        .dout_undef(dout_undef), .wr_strobe(wr_strobe)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_all();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        step(); step();
    endtask

    task automatic t_reset();
        check("R1 kind", cyc_kind, 0);
        check("R1 valid", cyc_valid, 0);
        check("R1 dout_en", dout_en, 0);
        check("R1 undef", dout_undef, 0);
        check("R1 row", refresh_row, 0);
        check("R1 fire/wr", {refresh_fire, wr_strobe}, 0);
    endtask

    task automatic t_read();
        addr = 9'h033; ras_n = 1'b0; step();
        check("R2 no decision at row fall", cyc_valid, 0);
        cas_n = 1'b0; oe_n = 1'b0; step();
        check("R2 read valid", cyc_valid, 1);
        check("R2 read kind", cyc_kind, 1);
        check("R8 driver on", dout_en, 1);
        oe_n = 1'b1; step();
        check("R8 off after oe rise", dout_en, 0);
        oe_n = 1'b0; step();
        check("R8 back on", dout_en, 1);
        cas_n = 1'b1; step();
        check("R8 off after cas rise", dout_en, 0);
        ras_n = 1'b1; step();
        check("R10 no refresh after access", {cyc_valid, refresh_fire}, 0);
        idle_all();
    endtask

    task automatic t_early_write();
        ras_n = 1'b0; step();
        we_n = 1'b0; oe_n = 1'b0; cas_n = 1'b0; step();
        check("R3 kind", cyc_kind, 2);
        check("R3 valid+wr", {cyc_valid, wr_strobe}, 3);
        check("R3 driver off", dout_en, 0);
        step();
        check("R3 single write pulse", wr_strobe, 0);
        check("R3 driver stays off", dout_en, 0);
        idle_all();
    endtask

    task automatic t_rmw();
        ras_n = 1'b0; step();
        cas_n = 1'b0; oe_n = 1'b0; step();
        check("R4 starts as read", cyc_kind, 1);
        step();
        check("R4 data driven before write", dout_en, 1);
        we_n = 1'b0; step();
        check("R4 kind", cyc_kind, 3);
        check("R4 valid+wr", {cyc_valid, wr_strobe}, 3);
        check("R4 data still driven", dout_en, 1);
        idle_all();
    endtask

    task automatic t_ras_only();
        addr = 9'h1A5; ras_n = 1'b0; step();
        addr = 9'h000; step();
        check("R5 nothing while low", cyc_valid, 0);
        ras_n = 1'b1; step();
        check("R5 kind", cyc_kind, 4);
        check("R5 fire", {cyc_valid, refresh_fire}, 3);
        check("R5 row from address", refresh_row, 9'h1A5);
        idle_all();
    endtask

    task automatic do_cbr(input string tag);
        cas_n = 1'b0; step();
        addr = 9'h0FF; ras_n = 1'b0; step();
        check({tag, " kind"}, cyc_kind, 5);
        check({tag, " fire"}, refresh_fire, 1);
        check({tag, " counter row"}, refresh_row, exp_cnt);
        exp_cnt = (exp_cnt + 1) % NROWS;
        ras_n = 1'b1; step();
        cas_n = 1'b1; step();
    endtask

    task automatic t_hidden();
        ras_n = 1'b0; step();
        cas_n = 1'b0; oe_n = 1'b0; step();
        check("R7 read first", dout_en, 1);
        ras_n = 1'b1; step();
        check("R7 data held, row high", dout_en, 1);
        check("R7 no decision yet", cyc_valid, 0);
        addr = 9'h0AA; ras_n = 1'b0; step();
        check("R7 kind", cyc_kind, 6);
        check("R7 fire", refresh_fire, 1);
        check("R7 counter row", refresh_row, exp_cnt);
        check("R7 data held in refresh", dout_en, 1);
        exp_cnt = (exp_cnt + 1) % NROWS;
        ras_n = 1'b1; step();
        check("R7 data held after refresh", dout_en, 1);
        cas_n = 1'b1; step();
        check("R8 off after cas rise", dout_en, 0);
        idle_all();
    endtask

    task automatic t_error();
        cas_n = 1'b0; step();
        ras_n = 1'b0; step();
        exp_cnt = (exp_cnt + 1) % NROWS;
        cas_n = 1'b1; step();
        cas_n = 1'b0; oe_n = 1'b0; step();
        check("R9 kind", cyc_kind, 7);
        check("R9 undef", dout_undef, 1);
        check("R9 driver off", dout_en, 0);
        ras_n = 1'b1; cas_n = 1'b1; oe_n = 1'b1; step();
        check("R9 undef clears", dout_undef, 0);
        idle_all();
    endtask

    task automatic t_page();
        ras_n = 1'b0; step();
        cas_n = 1'b0; step();
        check("R10 first column read", cyc_kind, 1);
        cas_n = 1'b1; step();
        we_n = 1'b0; cas_n = 1'b0; step();
        check("R10 second column early write", cyc_kind, 2);
        check("R10 second column valid", cyc_valid, 1);
        cas_n = 1'b1; we_n = 1'b1; step();
        cas_n = 1'b0; step();
        check("R10 third column read", cyc_kind, 1);
        cas_n = 1'b1; step();
        ras_n = 1'b1; step();
        check("R10 no refresh at row rise", {cyc_valid, refresh_fire}, 0);
        idle_all();
    endtask

    task automatic t_wrap();
        int left;
        left = NROWS - exp_cnt + 1;
        for (int i = 0; i < left; i++) do_cbr("R6 sweep");
        check("R6 wrapped to 1", exp_cnt, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        do_cbr("R1 R6 first refresh");
        t_read();
        t_early_write();
        t_rmw();
        t_ras_only();
        do_cbr("R6 ignores address");
        t_hidden();
        t_error();
        t_page();
        t_wrap();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule